// File: doc/BRIEF.md
# Transmit/Receive DMA Request Arbiter

This block shares one host-side DMA transfer channel between two requesters: the transmit side and the receive side of a buffered serial interface. Each side raises a request line. The arbiter picks one of them and drives a one-hot grant. The grant stays held for the whole transfer, and it is released only when the transfer-done strobe arrives.

The arbiter never takes the channel away from a transfer that is running. When both sides ask at the same time, the winner depends on the enable bits of the two FIFOs. Receive wins only when its read FIFO is enabled and the write FIFO is not. In every other configuration transmit wins.

The arbiter does not move any data. It only decides which side owns the channel and holds that decision. The requesters and the data path sit outside the block.

Top module: `txrx_dma_arb`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `grant` becomes 2'b00 at that edge, even if a transfer was in progress.
- R2: With the channel idle (`grant` == 2'b00), a lone transmit request sampled at a rising edge sets `grant` to 2'b01 (bit 0 = transmit) at that same edge.
- R3: With the channel idle, a lone receive request sampled at a rising edge sets `grant` to 2'b10 (bit 1 = receive) at that same edge.
- R4: With both FIFO enables high, simultaneous requests on an idle channel produce `grant` = 2'b01.
- R5: With only the write FIFO enable high, simultaneous requests on an idle channel produce `grant` = 2'b01.
- R6: With only the read FIFO enable high, simultaneous requests on an idle channel produce `grant` = 2'b10.
- R7: With neither FIFO enable high, simultaneous requests on an idle channel produce `grant` = 2'b01.
- R8: While `grant` is non-zero and `xfer_done` is low, `grant` keeps its value. Changes on either request line or on either FIFO enable do not alter it.
- R9: A high `xfer_done` sampled while a grant is held drives `grant` to 2'b00 at that edge. A new grant can appear no earlier than the following edge.
- R10: On an idle channel with no request, `grant` stays 2'b00, and a high `xfer_done` has no effect.
- R11: At most one bit of `grant` is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | Transmit-side DMA request |
| rx_req | input | 1 | Receive-side DMA request |
| wr_fifo_en | input | 1 | Write (transmit) FIFO enabled |
| rd_fifo_en | input | 1 | Read (receive) FIFO enabled |
| xfer_done | input | 1 | Current transfer has finished |
| grant | output | 2 | One-hot channel owner: bit 0 transmit, bit 1 receive |

## Verification
Lone requests in each direction show that the grant bit positions are not swapped. Simultaneous requests are applied under all four enable combinations. These separate the one receive-first configuration from the three transmit-first ones.

During held grants, the bench drops the owner's request, raises the other request, and changes the enables. This shows that the grant holds and is not re-arbitrated. Done strobes are applied with requests still pending, which exposes a grant that reappears on the release edge itself. Done strobes on an idle channel, and a reset in the middle of a transfer, confirm that neither leaves a stale grant.

// File: rtl/txrx_arb_pkg.sv
// Package: shared types for the transmit/receive DMA request arbiter.
// Assumes exactly two requesting directions; the index of each direction
// in a grant vector is fixed by dir_e and is visible at the top-level port.
package txrx_arb_pkg;

    localparam int unsigned NUM_DIR = 2;

    // Direction index inside request and grant vectors.
    typedef enum logic [0:0] {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef logic [NUM_DIR-1:0] dir_vec_t;

    localparam dir_vec_t NO_GRANT = '0;

    // One-hot vector for a single direction.
    function automatic dir_vec_t dir_onehot(input dir_e d);
        dir_vec_t v;
        v = '0;
        v[d] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/txrx_arb_prio.sv
// Module: txrx_arb_prio
// Purely combinational winner selection between the two directions.
// The preferred direction follows the FIFO enable configuration:
// receive is preferred only when the read FIFO is on and the write FIFO off.
// Assumes the caller uses 'winner' only while the channel is idle.
module txrx_arb_prio
    import txrx_arb_pkg::*;
(
    input  dir_vec_t req,
    input  logic     wr_fifo_en,
    input  logic     rd_fifo_en,
    output dir_vec_t winner,
    output logic     any_req
);

    logic     rx_first;
    dir_vec_t prefer;

    // Decide which direction wins a tie under the current enables.
    always_comb begin
        rx_first        = rd_fifo_en & ~wr_fifo_en;
        prefer          = '0;
        prefer[DIR_TX]  = ~rx_first;
        prefer[DIR_RX]  = rx_first;
    end

    // Each direction wins if it asks and is preferred or unopposed.
    for (genvar i = 0; i < NUM_DIR; i++) begin : g_win
        localparam int unsigned OTHER = NUM_DIR - 1 - i;
        always_comb winner[i] = req[i] & (prefer[i] | ~req[OTHER]);
    end

    // Flag that at least one direction is asking.
    always_comb any_req = |req;

endmodule

// File: rtl/txrx_arb_hold.sv
// Module: txrx_arb_hold
// Grant register. It loads the selected winner when the channel is idle
// and a request is present. It holds the grant unchanged until the done
// strobe, then clears it. Clearing and loading never happen on the same
// edge, so every transfer is followed by at least one idle cycle.
// Assumes 'winner' is one-hot or zero.
module txrx_arb_hold
    import txrx_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dir_vec_t winner,
    input  logic     any_req,
    input  logic     xfer_done,
    output dir_vec_t grant_q
);

    logic busy;

    // Channel is owned whenever any grant bit is held.
    always_comb busy = |grant_q;

    // Load, hold or release the grant on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= NO_GRANT;
        end else if (busy) begin
            if (xfer_done) begin
                grant_q <= NO_GRANT;
            end
        end else if (any_req) begin
            grant_q <= winner;
        end
    end

endmodule

// File: rtl/txrx_dma_arb.sv
// Module: txrx_dma_arb (top)
// Shares one DMA transfer channel between transmit and receive requests.
// It does not preempt a running transfer, and its tie-break follows the FIFO
// enables. Assumes requests stay high until granted, and that xfer_done is
// a single-cycle strobe from the data path.
module txrx_dma_arb
    import txrx_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_req,
    input  logic       rx_req,
    input  logic       wr_fifo_en,
    input  logic       rd_fifo_en,
    input  logic       xfer_done,
    output logic [1:0] grant
);

    dir_vec_t req_vec;
    dir_vec_t winner;
    logic     any_req;
    dir_vec_t grant_q;

    // Pack the request lines by direction index.
    always_comb begin
        req_vec         = '0;
        req_vec[DIR_TX] = tx_req;
        req_vec[DIR_RX] = rx_req;
    end

    txrx_arb_prio u_prio (
        .req        (req_vec),
        .wr_fifo_en (wr_fifo_en),
        .rd_fifo_en (rd_fifo_en),
        .winner     (winner),
        .any_req    (any_req)
    );

    txrx_arb_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .winner    (winner),
        .any_req   (any_req),
        .xfer_done (xfer_done),
        .grant_q   (grant_q)
    );

    // Drive the output grant straight from the register.
    always_comb grant = grant_q;

endmodule

// File: rtl/txrx_dma_arb_chk.sv
// Module: txrx_dma_arb_chk
// Property checker for txrx_dma_arb, attached through bind below.
// Only observes top-level ports.
module txrx_dma_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_req,
    input logic       rx_req,
    input logic       wr_fifo_en,
    input logic       rd_fifo_en,
    input logic       xfer_done,
    input logic [1:0] grant
);

    // R11: never more than one owner
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8: held grant is stable until done
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 2'b00 && !xfer_done) |=> grant == $past(grant));

    // R9: done releases the channel for one cycle
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 2'b00 && xfer_done) |=> grant == 2'b00);

    // R2: lone transmit on idle channel
    a_r2_tx_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b00 && tx_req && !rx_req) |=> grant == 2'b01);

    // R3: lone receive on idle channel
    a_r3_rx_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b00 && rx_req && !tx_req) |=> grant == 2'b10);

    // R6: receive wins ties only with read FIFO alone enabled
    a_r6_rx_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b00 && tx_req && rx_req && rd_fifo_en && !wr_fifo_en)
        |=> grant == 2'b10);

    // R4 R5 R7: transmit wins ties in all other configurations
    a_r4_tx_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b00 && tx_req && rx_req && !(rd_fifo_en && !wr_fifo_en))
        |=> grant == 2'b01);

    // R10: idle without requests stays idle
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b00 && !tx_req && !rx_req) |=> grant == 2'b00);

endmodule

bind txrx_dma_arb txrx_dma_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req     (tx_req),
    .rx_req     (rx_req),
    .wr_fifo_en (wr_fifo_en),
    .rd_fifo_en (rd_fifo_en),
    .xfer_done  (xfer_done),
    .grant      (grant)
);

// File: tb/txrx_dma_arb_test.sv
module txrx_dma_arb_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_req = 1'b0;
    logic       rx_req = 1'b0;
    logic       wr_fifo_en = 1'b0;
    logic       rd_fifo_en = 1'b0;
    logic       xfer_done = 1'b0;
    logic [1:0] grant;

    int checks = 0;
    int failures = 0;
    bit stim_done = 1'b0;
    bit finished = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    txrx_dma_arb uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_req     (tx_req),
        .rx_req     (rx_req),
        .wr_fifo_en (wr_fifo_en),
        .rd_fifo_en (rd_fifo_en),
        .xfer_done  (xfer_done),
        .grant      (grant)
    );

    // Driver: set inputs at a falling edge, queue grant expected after next rising edge.
    task automatic step(input logic rst, input logic tx, input logic rx,
                        input logic wen, input logic ren, input logic done,
                        input logic [1:0] exp, input string tag);
        @(negedge clk);
        rst_n      = rst;
        tx_req     = tx;
        rx_req     = rx;
        wr_fifo_en = wen;
        rd_fifo_en = ren;
        xfer_done  = done;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: one time unit after each rising edge, compare against queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (grant !== e) begin
                    failures++;
                    $display("FAIL %s grant actual=%b expected=%b", t, grant, e);
                end
                checks++;
                if ($countones(grant) > 1) begin
                    failures++;
                    $display("FAIL R11 grant actual=%b expected=onehot0", grant);
                end
            end
        end
    end

    // Stimulus: rst, tx, rx, wen, ren, done, expected grant after edge.
    initial begin
        step(0, 1, 1, 1, 1, 0, 2'b00, "R1 reset");
        step(0, 0, 0, 0, 0, 0, 2'b00, "R1 reset");
        step(1, 0, 0, 1, 1, 1, 2'b00, "R10 done while idle");
        step(1, 0, 0, 1, 1, 0, 2'b00, "R10 idle no request");
        step(1, 1, 0, 1, 1, 0, 2'b01, "R2 lone tx");
        step(1, 0, 1, 1, 1, 0, 2'b01, "R8 hold vs rx request");
        step(1, 1, 1, 0, 1, 0, 2'b01, "R8 hold vs config change");
        step(1, 1, 1, 1, 1, 1, 2'b00, "R9 release with pending reqs");
        step(1, 1, 1, 1, 1, 0, 2'b01, "R4 tie both enabled");
        step(1, 0, 0, 1, 1, 1, 2'b00, "R9 release");
        step(1, 0, 1, 0, 0, 0, 2'b10, "R3 lone rx");
        step(1, 1, 0, 1, 0, 0, 2'b10, "R8 hold vs tx request");
        step(1, 1, 1, 1, 0, 1, 2'b00, "R9 release rx");
        step(1, 1, 1, 1, 0, 0, 2'b01, "R5 tie write only");
        step(1, 1, 1, 0, 1, 1, 2'b00, "R9 release tie");
        step(1, 1, 1, 0, 1, 0, 2'b10, "R6 tie read only");
        step(1, 1, 1, 1, 1, 0, 2'b10, "R8 hold rx vs enables");
        step(1, 1, 1, 0, 0, 1, 2'b00, "R9 release");
        step(1, 1, 1, 0, 0, 0, 2'b01, "R7 tie none enabled");
        step(1, 0, 0, 0, 0, 1, 2'b00, "R9 release");
        step(1, 0, 0, 0, 0, 0, 2'b00, "R10 stays idle");
        step(1, 0, 1, 1, 1, 0, 2'b10, "R3 lone rx enabled");
        step(0, 0, 1, 1, 1, 0, 2'b00, "R1 reset mid transfer");
        step(1, 0, 0, 1, 1, 0, 2'b00, "R1 no stale grant");
        @(negedge clk);
        tx_req = 1'b0;
        rx_req = 1'b0;
        xfer_done = 1'b0;
        @(negedge clk);
        stim_done = 1'b1;
    end

    // Summary once all expected items are consumed.
    initial begin
        wait (stim_done && exp_q.size() == 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule